// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

This block adds two 16-bit operands and a carry-in, producing a 16-bit sum and a carry-out, all in pure combinational logic. The operand is split into four 4-bit groups. Inside each group every bit forms a generate term (both operand bits set) and a propagate term (operand bits differ), and every carry within the group is written as a flat sum of products of those terms and the group's incoming carry, so no carry ripples from bit to bit.

Each group also exports one group generate (the group produces a carry on its own) and one group propagate (a carry entering the group passes straight through it). A second-level lookahead unit turns these four pairs plus the adder's carry-in into the carry entering each group and the final carry-out, again as flat sums of products, so no carry ripples from group to group either. The block is meant to sit inside a datapath wherever a single-cycle 16-bit add is needed with a short carry path.

Top module: `lookahead_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `op_a + op_b + carry_in`, for every combination of inputs.
- R2: `carry_out` equals bit 16 of the 17-bit result of `op_a + op_b + carry_in`.
- R3: Each sum bit is the exclusive OR of the two operand bits at that position and the carry into that position; a position never both generates and propagates.
- R4: When every bit of a 4-bit group has differing operand bits (group propagate), the carry leaving the group equals the carry entering it, so `op_a = 0xFFFF`, `op_b = 0x0000` gives sum `0x0000` and `carry_out` 1 when `carry_in` is 1, and sum `0xFFFF`, `carry_out` 0 when it is 0.
- R5: When a group generates a carry (for instance both top bits of the group set), the next group receives a carry whatever the lower groups and `carry_in` hold.
- R6: A position where both operand bits are 0 stops an incoming carry: the sum bit there becomes 1 and no carry passes to the position above.
- R7: With `carry_in` 0, `0xFFFF + 0x0001` gives `sum_out = 0x0000` and `carry_out = 1`.
- R8: `carry_in` adds exactly one unit at bit 0: with both operands 0 the result is `sum_out = 0x0001`, `carry_out = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the sum |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
All-zero, all-one and alternating-bit operands, with and without carry-in, separate the sum bit equation from the carry path and show whether a carry crosses group boundaries at all. Operands chosen so one group only propagates, only generates or contains a killing position tell apart a wrong group propagate, a wrong group generate and a carry that leaks through a zero-zero position. Ten thousand pseudo-random operand pairs then catch any mis-indexed product term that the directed patterns leave untouched, each compared with a 17-bit behavioural addition.

// File: rtl/cla_pkg.sv
package cla_pkg;

  // Upper bound on the number of terms one lookahead function handles.
  localparam int MAX_TERMS = 64;

  typedef logic [MAX_TERMS-1:0] term_vec_t;

  // Carry into position k of a chain described by generate/propagate terms,
  // expanded as a flat sum of products: each product is one generate term
  // ANDed with every propagate above it, plus the incoming carry ANDed with
  // all propagates below k.
  function automatic logic lookahead_carry(input term_vec_t gen,
                                           input term_vec_t prop,
                                           input logic      c_in,
                                           input int        k);
    logic acc;
    logic prod;
    prod = c_in;
    for (int m = 0; m < k; m++) prod = prod & prop[m];
    acc = prod;
    for (int j = 0; j < k; j++) begin
      prod = gen[j];
      for (int m = j + 1; m < k; m++) prod = prod & prop[m];
      acc = acc | prod;
    end
    return acc;
  endfunction

  // AND of the first n propagate terms.
  function automatic logic all_propagate(input term_vec_t prop, input int n);
    logic acc;
    acc = 1'b1;
    for (int m = 0; m < n; m++) acc = acc & prop[m];
    return acc;
  endfunction

  function automatic logic bit_generate(input logic x, input logic y);
    return x & y;
  endfunction

  function automatic logic bit_propagate(input logic x, input logic y);
    return x ^ y;
  endfunction

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg (
  input  logic x_bit,
  input  logic y_bit,
  output logic gen_bit,
  output logic prop_bit
);
  import cla_pkg::*;

  assign gen_bit  = bit_generate(x_bit, y_bit);
  assign prop_bit = bit_propagate(x_bit, y_bit);

  // R3: a position never generates and propagates at once
  always_comb begin
    if (!$isunknown({x_bit, y_bit}))
      assert_pg_exclusive_R3: assert (!(gen_bit && prop_bit))
        else $error("generate and propagate both high");
  end

endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GRP_W = 4
) (
  input  logic [GRP_W-1:0] a_in,
  input  logic [GRP_W-1:0] b_in,
  input  logic             c_in,
  output logic [GRP_W-1:0] s_out,
  output logic             grp_gen,
  output logic             grp_prop
);
  import cla_pkg::*;

  logic [GRP_W-1:0] gen_v;
  logic [GRP_W-1:0] prop_v;
  logic [GRP_W:0]   carry_v;   // carry_v[GRP_W] exists for the checks only
  term_vec_t        gen_pad;
  term_vec_t        prop_pad;

  for (genvar i = 0; i < GRP_W; i++) begin : g_bit
    cla_bit_pg u_pg (
      .x_bit   (a_in[i]),
      .y_bit   (b_in[i]),
      .gen_bit (gen_v[i]),
      .prop_bit(prop_v[i])
    );
  end

  always_comb begin
    gen_pad  = '0;
    prop_pad = '0;
    gen_pad[GRP_W-1:0]  = gen_v;
    prop_pad[GRP_W-1:0] = prop_v;
  end

  // Every internal carry computed straight from the terms and c_in.
  for (genvar k = 0; k <= GRP_W; k++) begin : g_carry
    assign carry_v[k] = lookahead_carry(gen_pad, prop_pad, c_in, k);
  end

  assign s_out    = prop_v ^ carry_v[GRP_W-1:0];
  assign grp_gen  = lookahead_carry(gen_pad, prop_pad, 1'b0, GRP_W);
  assign grp_prop = all_propagate(prop_pad, GRP_W);

  always_comb begin
    if (!$isunknown({a_in, b_in, c_in})) begin
      // R4: a propagating group hands its incoming carry straight through
      if (grp_prop)
        assert_grp_pass_R4: assert (carry_v[GRP_W] == c_in)
          else $error("group propagate did not pass carry");
      // R5: a generating group always emits a carry
      if (grp_gen)
        assert_grp_emit_R5: assert (carry_v[GRP_W])
          else $error("group generate without carry out");
      // R3: group slice equals arithmetic sum of its bits
      assert_grp_sum_R3: assert ({carry_v[GRP_W], s_out} ==
                                  ({1'b0, a_in} + {1'b0, b_in} + {{GRP_W{1'b0}}, c_in}))
        else $error("group slice sum mismatch");
    end
  end

endmodule

// File: rtl/cla_group_lookahead.sv
module cla_group_lookahead #(
  parameter int NUM_GRP = 4
) (
  input  logic [NUM_GRP-1:0] grp_gen,
  input  logic [NUM_GRP-1:0] grp_prop,
  input  logic               c_in,
  output logic [NUM_GRP-1:0] grp_cin,
  output logic               c_out
);
  import cla_pkg::*;

  term_vec_t gen_pad;
  term_vec_t prop_pad;

  always_comb begin
    gen_pad  = '0;
    prop_pad = '0;
    gen_pad[NUM_GRP-1:0]  = grp_gen;
    prop_pad[NUM_GRP-1:0] = grp_prop;
  end

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_cin
    assign grp_cin[j] = lookahead_carry(gen_pad, prop_pad, c_in, j);
  end

  assign c_out = lookahead_carry(gen_pad, prop_pad, c_in, NUM_GRP);

  always_comb begin
    if (!$isunknown({grp_gen, grp_prop, c_in})) begin
      assert_first_cin_R8: assert (grp_cin[0] == c_in)
        else $error("carry into first group differs from carry_in");
      for (int j = 0; j < NUM_GRP - 1; j++) begin
        // R5: carry into group j+1 follows one group-level step
        assert_step_R5: assert (grp_cin[j+1] == (grp_gen[j] | (grp_prop[j] & grp_cin[j])))
          else $error("group carry step mismatch at %0d", j);
      end
    end
  end

endmodule

// File: rtl/lookahead_adder.sv
module lookahead_adder #(
  parameter int GRP_W   = 4,
  parameter int NUM_GRP = 4
) (
  input  logic [GRP_W*NUM_GRP-1:0] op_a,
  input  logic [GRP_W*NUM_GRP-1:0] op_b,
  input  logic                     carry_in,
  output logic [GRP_W*NUM_GRP-1:0] sum_out,
  output logic                     carry_out
);
  localparam int WIDTH = GRP_W * NUM_GRP;

  logic [NUM_GRP-1:0] grp_gen;
  logic [NUM_GRP-1:0] grp_prop;
  logic [NUM_GRP-1:0] grp_cin;

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp
    cla_group #(.GRP_W(GRP_W)) u_group (
      .a_in    (op_a[j*GRP_W +: GRP_W]),
      .b_in    (op_b[j*GRP_W +: GRP_W]),
      .c_in    (grp_cin[j]),
      .s_out   (sum_out[j*GRP_W +: GRP_W]),
      .grp_gen (grp_gen[j]),
      .grp_prop(grp_prop[j])
    );
  end

  cla_group_lookahead #(.NUM_GRP(NUM_GRP)) u_top_la (
    .grp_gen (grp_gen),
    .grp_prop(grp_prop),
    .c_in    (carry_in),
    .grp_cin (grp_cin),
    .c_out   (carry_out)
  );

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      assert_sum_R1: assert (sum_out == ref_total[WIDTH-1:0])
        else $error("sum mismatch");
      assert_cout_R2: assert (carry_out == ref_total[WIDTH])
        else $error("carry out mismatch");
    end
  end

endmodule

// File: tb/lookahead_adder_bench.sv
module lookahead_adder_bench;

  logic        clk = 1'b0;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum_out;
  logic        carry_out;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  lookahead_adder u_lookahead_adder (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_out  (sum_out),
    .carry_out(carry_out)
  );

  // Drive one vector away from the edge, sample 2 ns later, compare.
  task automatic apply(input logic [15:0] a, input logic [15:0] b,
                       input logic c, input string tag);
    logic [16:0] exp_total;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c;
    #2;
    exp_total = 17'(a) + 17'(b) + 17'(c);
    vectors++;
    if (sum_out !== exp_total[15:0]) begin
      miscompares++;
      $display("FAIL %s sum a=%h b=%h cin=%b: got %h expected %h",
               tag, a, b, c, sum_out, exp_total[15:0]);
    end
    if (carry_out !== exp_total[16]) begin
      miscompares++;
      $display("FAIL %s carry a=%h b=%h cin=%b: got %b expected %b",
               tag, a, b, c, carry_out, exp_total[16]);
    end
  endtask

  // Checks a specific expected pair as well as the reference.
  task automatic apply_exact(input logic [15:0] a, input logic [15:0] b,
                             input logic c, input logic [15:0] s_exp,
                             input logic co_exp, input string tag);
    apply(a, b, c, tag);
    vectors++;
    if (sum_out !== s_exp || carry_out !== co_exp) begin
      miscompares++;
      $display("FAIL %s exact: got %h/%b expected %h/%b",
               tag, sum_out, carry_out, s_exp, co_exp);
    end
  endtask

  task automatic test_zero_inputs();
    apply_exact(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R1/R2 zero");
    apply_exact(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, "R8 cin only");
  endtask

  task automatic test_all_ones();
    apply_exact(16'hFFFF, 16'hFFFF, 1'b0, 16'hFFFE, 1'b1, "R1/R2 ones");
    apply_exact(16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1, "R1/R2 ones cin");
  endtask

  task automatic test_alternating();
    apply_exact(16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0, "R3 alt");
    apply_exact(16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1, "R3 alt cin");
    apply(16'hAAAA, 16'hAAAA, 1'b0, "R3 alt same");
    apply(16'h5555, 16'h5555, 1'b1, "R3 alt same cin");
  endtask

  task automatic test_full_propagate();
    apply_exact(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R4 pass cin");
    apply_exact(16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, "R4 no cin");
    apply_exact(16'h0F0F, 16'hF0F0, 1'b1, 16'h0000, 1'b1, "R4 mixed");
  endtask

  task automatic test_group_generate();
    // group 1 top bits both set: carry into group 2 regardless of below
    apply_exact(16'h0800, 16'h0800, 1'b0, 16'h1000, 1'b0, "R5 gen g1");
    apply_exact(16'h08FF, 16'h0800, 1'b1, 16'h1100, 1'b0, "R5 gen g1 cin");
    apply_exact(16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, "R5 gen g3");
    apply_exact(16'h0008, 16'h0FF8, 1'b0, 16'h1000, 1'b0, "R5 gen chain");
  endtask

  task automatic test_kill();
    // bit 4 has 0/0: carry from group 0 stops there
    apply_exact(16'hFFEF, 16'h0000, 1'b1, 16'hFFF0, 1'b0, "R6 kill b4");
    apply_exact(16'h7FFF, 16'h0000, 1'b1, 16'h8000, 1'b0, "R6 kill b15");
  endtask

  task automatic test_wrap();
    apply_exact(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R7 wrap");
    apply_exact(16'h0001, 16'hFFFF, 1'b0, 16'h0000, 1'b1, "R7 wrap swapped");
  endtask

  task automatic test_random();
    for (int n = 0; n < 10000; n++) begin
      logic [31:0] r;
      r = $urandom();
      apply(r[15:0], r[31:16], 1'($urandom() & 1), "R1/R2 random");
    end
  endtask

  initial begin
    #1;
    // reset state: zero inputs drive zero outputs
    vectors++;
    if (sum_out !== 16'h0000 || carry_out !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 idle: got %h/%b expected 0000/0", sum_out, carry_out);
    end
    test_zero_inputs();
    test_all_ones();
    test_alternating();
    test_full_propagate();
    test_group_generate();
    test_kill();
    test_wrap();
    test_random();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule